// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Wake-Up

This block receives asynchronous serial frames on a shared multidrop line. Every frame carries eight data bits, least significant first, then a ninth marker bit and one stop bit. No parity bit is used. A marker of 1 tags the frame as a station address, and a marker of 0 tags it as payload. Each bit is timed from a 16x oversampling tick supplied from outside the block, and a two-flop synchronizer sits on the line.

A host on the same chip reads one packed word that holds the byte, its marker, a framing-error flag and an overrun flag. A read strobe clears all flags. The host can arm a wake-up mode by writing a control bit. While the mode is armed, payload frames are discarded without a trace: the buffer is not loaded, no error is recorded and no flag is raised. The first address frame is delivered with its marker set to 1, and that frame disarms the mode. The host compares the address itself. If the address is not its own, the host re-arms the mode.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, `rx_full_o`, `wake_o` and every bit of `rd_data_o` read 0.
- R2: A frame is a low start bit, eight data bits LSB first, one marker bit and one stop bit. When the frame completes, the byte appears in `rd_data_o[7:0]`, the marker appears in `rd_data_o[8]`, and `rx_full_o` goes to 1.
- R3: With wake-up disarmed, marker-0 frames are delivered normally with `rd_data_o[8]` = 0.
- R4: A start edge counts only if the line is still low at the start bit's midpoint, 8 ticks later. A shorter low pulse produces no frame, and the receiver stays ready for the next frame.
- R5: A stop bit sampled low sets `rd_data_o[9]`. The byte is still loaded.
- R6: If a frame completes while `rx_full_o` is 1 and no read occurs, `rd_data_o[10]` goes to 1 and the earlier byte and marker are kept.
- R7: `rd_i` clears `rx_full_o`, `rd_data_o[9]` and `rd_data_o[10]`.
- R8: While `wake_o` is 1, a marker-0 frame leaves `rx_full_o`, the byte, the marker and both error flags unchanged, even when its stop bit is bad.
- R9: While `wake_o` is 1, a marker-1 frame is delivered with `rd_data_o[8]` = 1 and `rx_full_o` = 1, and `wake_o` returns to 0.
- R10: After the mode disarms, later frames, including marker-0 frames, are received normally. This includes overrun detection.
- R11: A pulse on `wake_we_i` loads `wake_wd_i` into `wake_o` at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rd_i | input | 1 | Host read strobe, clears flags |
| wake_we_i | input | 1 | Write strobe for the wake-up control |
| wake_wd_i | input | 1 | Value written to the wake-up control |
| rd_data_o | output | 11 | {overrun, framing err, marker, byte[7:0]} |
| rx_full_o | output | 1 | Receive-complete flag |
| wake_o | output | 1 | Wake-up mode armed |

## Verification
The bench sends a marker-0 frame with a bad stop bit while the mode is armed. A receiver that still records errors during wake-up would set the framing flag on that frame. Next, the bench leaves the waking address frame unread and sends a payload frame behind it. A design that overwrites the buffer, or that stays asleep after the address frame, would lose the address or never flag the overrun. A short start glitch checks the midpoint validation. A design that accepts the glitch would shift in a phantom frame.

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              rd_i,
  input  logic              wake_we_i,
  input  logic              wake_wd_i,
  output logic [DATA_W+2:0] rd_data_o,
  output logic              rx_full_o,
  output logic              wake_o
);
  localparam int CW   = $clog2(OSR);
  localparam int NB   = DATA_W + 1;
  localparam int BW   = $clog2(NB + 1);
  localparam int HALF = OSR / 2 - 1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_SHIFT, S_STOP} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] nbit;
  logic [NB-1:0] sh;
  logic [1:0]    sync;
  logic [DATA_W-1:0] data_q;
  logic          mark_q, full, fer, ovr, wake;

  wire rx_s   = sync[1];
  wire done   = tick_i && state == S_STOP && cnt == CW'(OSR - 1);
  wire marker = sh[NB-1];
  wire accept = done && (!wake || marker);

  assign rd_data_o = {ovr, fer, mark_q, data_q};
  assign rx_full_o = full;
  assign wake_o    = wake;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      nbit  <= '0;
      sh    <= '0;
    end else if (tick_i) begin
      case (state)
        S_IDLE: if (!rx_s) begin
          state <= S_START;
          cnt   <= '0;
        end
        S_START: if (cnt == CW'(HALF)) begin
          cnt   <= '0;
          nbit  <= '0;
          state <= rx_s ? S_IDLE : S_SHIFT;
        end else cnt <= cnt + 1'b1;
        S_SHIFT: if (cnt == CW'(OSR - 1)) begin
          cnt <= '0;
          sh  <= {rx_s, sh[NB-1:1]};
          if (nbit == BW'(NB - 1)) state <= S_STOP;
          else                     nbit  <= nbit + 1'b1;
        end else cnt <= cnt + 1'b1;
        S_STOP: if (cnt == CW'(OSR - 1)) begin
          cnt   <= '0;
          state <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mark_q <= 1'b0;
      full   <= 1'b0;
      fer    <= 1'b0;
      ovr    <= 1'b0;
      wake   <= 1'b0;
    end else begin
      if (rd_i) begin
        full <= 1'b0;
        fer  <= 1'b0;
        ovr  <= 1'b0;
      end
      if (accept) begin
        if (full && !rd_i) ovr <= 1'b1;
        else begin
          data_q <= sh[DATA_W-1:0];
          mark_q <= marker;
          fer    <= !rx_s;
          full   <= 1'b1;
        end
      end
      if (wake_we_i)             wake <= wake_wd_i;
      else if (done && marker)   wake <= 1'b0;
    end
  end

  // R2
  full_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(done));

  // R6
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && full && !rd_i && !wake |=> ovr && $stable(data_q) && $stable(mark_q));

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i && !done |=> !full && !fer && !ovr);

  // R8
  wake_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake && done && !marker && !rd_i |=> $stable({full, fer, ovr, mark_q, data_q}));

  // R9
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake && done && marker && !wake_we_i |=> !wake && full && mark_q);
endmodule

// File: tb/tb_mp_uart_rx.sv
`timescale 1ns/1ps
module tb_mp_uart_rx;
  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, rd = 1'b0, wwe = 1'b0, wwd = 1'b0;
  logic [1:0] tdiv = '0;
  logic tick;
  logic [10:0] rdata;
  logic full, wake;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;
  always_ff @(posedge clk) tdiv <= tdiv + 1'b1;
  assign tick = (tdiv == 2'd3);

  mp_uart_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .rd_i(rd),
    .wake_we_i(wwe), .wake_wd_i(wwd), .rd_data_o(rdata),
    .rx_full_o(full), .wake_o(wake)
  );

  // arm, data, mark, stop, read-after, exp full, exp rd_data, exp wake
  typedef struct packed {
    logic arm; logic [7:0] d; logic m; logic s; logic rdaf;
    logic efull; logic [10:0] erd; logic ewake;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{1'b0, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b1, 11'h0A5, 1'b0}, // R2 R3
    '{1'b0, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b1, 11'h13C, 1'b0}, // R2
    '{1'b0, 8'h81, 1'b0, 1'b0, 1'b1, 1'b1, 11'h281, 1'b0}, // R5
    '{1'b1, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0, 11'h081, 1'b1}, // R8
    '{1'b0, 8'h66, 1'b0, 1'b0, 1'b0, 1'b0, 11'h081, 1'b1}, // R8 bad stop ignored
    '{1'b0, 8'h02, 1'b1, 1'b1, 1'b0, 1'b1, 11'h102, 1'b0}, // R9
    '{1'b0, 8'h77, 1'b0, 1'b1, 1'b1, 1'b1, 11'h502, 1'b0}, // R6 R10
    '{1'b0, 8'hC3, 1'b0, 1'b1, 1'b1, 1'b1, 11'h0C3, 1'b0}  // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) rx = b;
    repeat (63) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic m, input logic s);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(m);
    send_bit(s);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_wake(input logic v);
    @(negedge clk) begin wwe = 1'b1; wwd = v; end
    @(negedge clk) wwe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1
    chk("R1 full", full, 0);
    chk("R1 wake", wake, 0);
    chk("R1 rd_data", rdata, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      if (VT[k].arm) write_wake(1'b1);
      send_frame(VT[k].d, VT[k].m, VT[k].s);
      chk($sformatf("vec%0d full R2", k), full, VT[k].efull);
      chk($sformatf("vec%0d rd_data R2", k), rdata, VT[k].erd);
      chk($sformatf("vec%0d wake R9", k), wake, VT[k].ewake);
      if (VT[k].rdaf) begin
        pulse_rd();
        chk($sformatf("vec%0d R7 full", k), full, 0);
        chk($sformatf("vec%0d R7 flags", k), rdata[10:9], 0);
      end
    end

    // R4: glitch of 4 ticks on the line
    @(negedge clk) rx = 1'b0;
    repeat (16) @(negedge clk);
    rx = 1'b1;
    repeat (16 * 64) @(negedge clk);
    chk("R4 glitch full", full, 0);
    chk("R4 glitch data", rdata, 11'h0C3);
    send_frame(8'h5A, 1'b0, 1'b1);
    chk("R4 recover full", full, 1);
    chk("R4 recover data", rdata, 11'h05A);
    pulse_rd();

    // R11
    write_wake(1'b1);
    chk("R11 set", wake, 1);
    write_wake(1'b0);
    chk("R11 clear", wake, 0);
    send_frame(8'h11, 1'b0, 1'b1);
    chk("R11 R3 normal after clear", rdata, 11'h011);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule